// File: doc/BRIEF.md
# Completion Interrupt Coalescing Unit

This unit serves a single work queue. It counts the completed items that asked for an interrupt and decides when to raise one level interrupt for all of them. Each completion pulse carries a request flag. Only flagged completions add one to a 20-bit pending count. Software reads the count and returns what it has serviced by writing an acknowledge value, which the unit subtracts.

Two hold-off limits decide when the interrupt fires, and either one is enough. The first is a count limit: the pending count has reached a programmed number. The second is a time limit: a timer that runs while anything is pending has reached a programmed value scaled by 1024. The timer restarts on every acknowledge, and the decision is then taken again straight away. Because of this, completions that arrive while software is servicing cannot be stranded. An enable bit masks the output but does not stop counting or timing.

Registers sit on a small word port. The write takes effect at the clock edge and the read is combinational. Address 0 holds the done count (a write loads it directly). Address 1 is the acknowledge register (a write subtracts, a read returns the count). Address 2 holds the wait settings. Address 3 holds the enable in bit 0.

Top module: `irq_coalesce`

## Requirements
- R1: A completion pulse with its request flag set raises the done count by one at the next edge. A pulse with the flag clear leaves the count unchanged.
- R2: A write to address 1 subtracts the low 20 bits of the written data from the done count. If the value exceeds the count, the count becomes zero.
- R3: A read at address 1 or address 0 returns the current done count in bits 19:0, with the upper bits zero.
- R4: While the done count is zero, the interrupt stays low and the timer stays at zero, however long the count remains zero. After reset, the count, wait settings and enable are all zero.
- R5: The interrupt is high whenever the count is nonzero and at least the count limit. A count limit of zero behaves as a limit of one.
- R6: When the count goes from zero to nonzero at edge k, with time limit T nonzero, the interrupt rises at edge k+T*1024 if the count limit is not met. A time limit of zero never fires.
- R7: A write to address 1 or address 0 restarts the timer from zero. The interrupt is then re-decided at once: it stays or comes back high at that same edge if the remaining count still meets the count limit.
- R8: With the enable (address 3, bit 0) clear, the interrupt output is low. The count and timer keep running, and setting the enable shows the pending state at the next edge.
- R9: A flagged completion and an acknowledge in the same cycle give a count of old + 1 − ack.
- R10: A write to address 0 loads the done count with the low 20 bits of the data.
- R11: The wait settings at address 2 hold the count limit in bits 19:0 and the time limit in bits 47:32. A read at address 2 returns them in the same positions, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_valid | input | 1 | One-cycle pulse per completed item |
| cmp_irq_req | input | 1 | The completing item requests an interrupt |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 done, 1 ack, 2 wait, 3 enable) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| done_count_o | output | 20 | Current done count |
| irq_o | output | 1 | Level completion interrupt |

## Verification
Errors in the count show up on done_count_o one edge after the completion or write that caused them. A missing saturation or a lost simultaneous increment is therefore caught on the next sample. A timer that is not held or not restarted gives no sign until the time limit expires. For that reason the time path is checked at the exact edge k+T*1024 and one edge earlier, both from a fresh start and after an acknowledge restart. A wrong decision on the count path flips irq_o at the same edge as the count change. This includes the immediate re-raise after an acknowledge that leaves the limit met.

// File: rtl/irq_coal_pkg.sv
// Shared register address map for the completion interrupt coalescing unit.
// Assumes a 2-bit word address on the register port.
package irq_coal_pkg;
    typedef enum logic [1:0] {
        ADDR_DONE = 2'd0,
        ADDR_ACK  = 2'd1,
        ADDR_WAIT = 2'd2,
        ADDR_ENA  = 2'd3
    } coal_addr_e;

    // Bit position of the time limit inside the wait-settings word.
    localparam int TIME_LSB = 32;
endpackage

// File: rtl/coal_regs.sv
// Register decode and the settings registers (wait limits, enable).
// Provides both the current and the next-edge values of the settings, so that
// the decision stage sees a write at the same edge it lands.
// Assumes DATA_W >= TIME_LSB + TW_W.
module coal_regs
    import irq_coal_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int TW_W   = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_done,
    output logic              wr_ack,
    output logic [CNT_W-1:0]  wr_val,
    output logic [CNT_W-1:0]  num_q,
    output logic [TW_W-1:0]   tw_q,
    output logic [CNT_W-1:0]  num_nx,
    output logic [TW_W-1:0]   tw_nx,
    output logic              ena_q
);
    localparam int TIME_MSB = TIME_LSB + TW_W - 1;

    logic wr_wait;
    logic wr_ena;
    logic ena_nx;

    // Decode write strobes and form next settings values.
    always_comb begin
        wr_done = wr_en && (addr == ADDR_DONE);
        wr_ack  = wr_en && (addr == ADDR_ACK);
        wr_wait = wr_en && (addr == ADDR_WAIT);
        wr_ena  = wr_en && (addr == ADDR_ENA);
        wr_val  = wdata[CNT_W-1:0];
        num_nx  = wr_wait ? wdata[CNT_W-1:0]         : num_q;
        tw_nx   = wr_wait ? wdata[TIME_MSB:TIME_LSB] : tw_q;
        ena_nx  = wr_ena  ? wdata[0]                 : ena_q;
    end

    // Hold the settings registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q <= '0;
            tw_q  <= '0;
            ena_q <= 1'b0;
        end else begin
            num_q <= num_nx;
            tw_q  <= tw_nx;
            ena_q <= ena_nx;
        end
    end
endmodule

// File: rtl/coal_counter.sv
// Pending-completion counter. Adds one per flagged completion, subtracts an
// acknowledge value, or loads a direct value (plus a same-cycle completion).
// Floors at zero and saturates at all-ones. Load and subtract never coincide.
module coal_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic             sub,
    input  logic [CNT_W-1:0] val,
    output logic [CNT_W-1:0] cnt_nx,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] base;
    logic [CNT_W:0] sum;
    logic [CNT_W:0] dec;
    logic [CNT_W:0] diff;

    // Compute the next count with floor and ceiling.
    always_comb begin
        base = load ? {1'b0, val} : {1'b0, cnt_q};
        sum  = base + {{CNT_W{1'b0}}, inc};
        dec  = sub ? {1'b0, val} : '0;
        diff = (dec >= sum) ? '0 : (sum - dec);
        cnt_nx = (diff > MAXV) ? MAXV[CNT_W-1:0] : diff[CNT_W-1:0];
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/coal_timer.sv
// Hold-off timer. Runs while anything is pending, stays at zero while idle,
// restarts on request, and stops at its maximum instead of wrapping.
module coal_timer #(
    parameter int TMR_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    output logic [TMR_W-1:0] tmr_nx,
    output logic [TMR_W-1:0] tmr_q
);
    // Choose the next timer value.
    always_comb begin
        if (restart || !active)     tmr_nx = '0;
        else if (tmr_q == '1)       tmr_nx = tmr_q;
        else                        tmr_nx = tmr_q + 1'b1;
    end

    // Register the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_nx;
    end
endmodule

// File: rtl/coal_decide.sv
// Interrupt decision. Evaluates the limits on next-edge state, so the
// registered result always matches the registered count, timer and settings.
module coal_decide #(
    parameter int CNT_W      = 20,
    parameter int TW_W       = 16,
    parameter int SCALE_LOG2 = 10,
    parameter int TMR_W      = TW_W + SCALE_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic [TMR_W-1:0] tmr_nx,
    input  logic [CNT_W-1:0] num_nx,
    input  logic [TW_W-1:0]  tw_nx,
    output logic             irq_q
);
    logic [CNT_W-1:0] num_eff;
    logic [TMR_W-1:0] tmr_lim;
    logic             hit_cnt;
    logic             hit_tmr;
    logic             irq_nx;

    // Evaluate the count and time limits.
    always_comb begin
        num_eff = (num_nx == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : num_nx;
        tmr_lim = {tw_nx, {SCALE_LOG2{1'b0}}};
        hit_cnt = (cnt_nx >= num_eff);
        hit_tmr = (tw_nx != '0) && (tmr_nx >= tmr_lim);
        irq_nx  = (cnt_nx != '0) && (hit_cnt || hit_tmr);
    end

    // Register the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_nx;
    end
endmodule

// File: rtl/irq_coalesce.sv
// Top of the completion interrupt coalescing unit for one queue.
// Assumes completions are single-cycle pulses and register reads have no
// side effects. The output is the registered decision gated by the enable.
module irq_coalesce
    import irq_coal_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int TW_W       = 16,
    parameter int SCALE_LOG2 = 10,
    parameter int DATA_W     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic              cmp_irq_req,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  done_count_o,
    output logic              irq_o
);
    localparam int TMR_W = TW_W + SCALE_LOG2;

    logic             wr_done, wr_ack;
    logic [CNT_W-1:0] wr_val;
    logic [CNT_W-1:0] num_q, num_nx;
    logic [TW_W-1:0]  tw_q, tw_nx;
    logic             ena_q;
    logic [CNT_W-1:0] cnt_nx, cnt_q;
    logic [TMR_W-1:0] tmr_nx, tmr_q;
    logic             irq_q;
    logic             inc;

    coal_regs #(.CNT_W(CNT_W), .TW_W(TW_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .wr_done(wr_done), .wr_ack(wr_ack),
        .wr_val(wr_val), .num_q(num_q), .tw_q(tw_q), .num_nx(num_nx),
        .tw_nx(tw_nx), .ena_q(ena_q)
    );

    // Qualify a completion by its interrupt request flag.
    always_comb inc = cmp_valid && cmp_irq_req;

    coal_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .load(wr_done), .sub(wr_ack),
        .val(wr_val), .cnt_nx(cnt_nx), .cnt_q(cnt_q)
    );

    coal_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(wr_done || wr_ack),
        .active(cnt_q != '0), .tmr_nx(tmr_nx), .tmr_q(tmr_q)
    );

    coal_decide #(.CNT_W(CNT_W), .TW_W(TW_W), .SCALE_LOG2(SCALE_LOG2),
                  .TMR_W(TMR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cnt_nx(cnt_nx), .tmr_nx(tmr_nx),
        .num_nx(num_nx), .tw_nx(tw_nx), .irq_q(irq_q)
    );

    // Drive outputs: gated interrupt, count and read mux.
    always_comb begin
        irq_o        = irq_q && ena_q;
        done_count_o = cnt_q;
        reg_rdata    = '0;
        case (reg_addr)
            ADDR_DONE, ADDR_ACK: reg_rdata[CNT_W-1:0] = cnt_q;
            ADDR_WAIT: begin
                reg_rdata[CNT_W-1:0]                  = num_q;
                reg_rdata[TIME_LSB +: TW_W]           = tw_q;
            end
            default:   reg_rdata[0] = ena_q;
        endcase
    end
endmodule

// File: rtl/coal_chk.sv
// Property checker for irq_coalesce, attached by the bind below.
module coal_chk #(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_valid,
    input logic              cmp_irq_req,
    input logic              reg_wr_en,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [CNT_W-1:0]  done_count_o,
    input logic              irq_o,
    input logic              ena_q,
    input logic [CNT_W-1:0]  num_q
);
    a_r1_flagged_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_irq_req && !reg_wr_en && done_count_o != '1)
        |=> (done_count_o == $past(done_count_o) + {{(CNT_W-1){1'b0}}, 1'b1}));

    a_r1_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmp_valid && cmp_irq_req) && !reg_wr_en) |=> $stable(done_count_o));

    a_r2_ack_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 2'd1 && !(cmp_valid && cmp_irq_req)
         && reg_wdata[CNT_W-1:0] >= done_count_o) |=> (done_count_o == '0));

    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done_count_o == '0) |-> !irq_o);

    a_r5_count_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q && done_count_o != '0 && done_count_o >= num_q) |-> irq_o);

    a_r8_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_q |-> !irq_o);
endmodule

bind irq_coalesce coal_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_irq_req(cmp_irq_req),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .done_count_o(done_count_o), .irq_o(irq_o), .ena_q(ena_q), .num_q(num_q)
);

// File: tb/sim_irq_coalesce.sv
module sim_irq_coalesce;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic        cmp_irq_req = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [19:0] done_count_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    irq_coalesce u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
        .cmp_irq_req(cmp_irq_req), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_count_o(done_count_o), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    // Vector: {op[2:0] = {unflagged, write, flagged}, addr, data[47:0], done, irq}
    localparam int NV = 20;
    localparam logic [73:0] VEC [NV] = '{
        {3'b010, 2'd3, 48'd1,  20'd0, 1'b0},
        {3'b010, 2'd2, 48'd3,  20'd0, 1'b0},
        {3'b001, 2'd0, 48'd0,  20'd1, 1'b0},
        {3'b100, 2'd0, 48'd0,  20'd1, 1'b0},
        {3'b001, 2'd0, 48'd0,  20'd2, 1'b0},
        {3'b001, 2'd0, 48'd0,  20'd3, 1'b1},
        {3'b010, 2'd1, 48'd1,  20'd2, 1'b0},
        {3'b011, 2'd1, 48'd2,  20'd1, 1'b0},
        {3'b001, 2'd0, 48'd0,  20'd2, 1'b0},
        {3'b001, 2'd0, 48'd0,  20'd3, 1'b1},
        {3'b011, 2'd1, 48'd1,  20'd3, 1'b1},
        {3'b010, 2'd1, 48'd10, 20'd0, 1'b0},
        {3'b010, 2'd0, 48'd5,  20'd5, 1'b1},
        {3'b010, 2'd3, 48'd0,  20'd5, 1'b0},
        {3'b001, 2'd0, 48'd0,  20'd6, 1'b0},
        {3'b010, 2'd3, 48'd1,  20'd6, 1'b1},
        {3'b010, 2'd2, 48'd0,  20'd6, 1'b1},
        {3'b010, 2'd1, 48'd6,  20'd0, 1'b0},
        {3'b001, 2'd0, 48'd0,  20'd1, 1'b1},
        {3'b010, 2'd1, 48'd1,  20'd0, 1'b0}
    };
    string VTAG [NV] = '{"R8", "R11", "R1", "R1", "R1", "R5", "R2", "R9",
                         "R1", "R5", "R7", "R2", "R10", "R8", "R8", "R8",
                         "R5", "R2", "R5", "R2"};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One operation through one edge; returns 3 ns after that edge.
    task automatic apply(input logic [2:0] op, input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        cmp_valid   = op[0] | op[2];
        cmp_irq_req = op[0];
        reg_wr_en   = op[1];
        reg_addr    = a;
        reg_wdata   = d;
        @(posedge clk);
        #1;
        cmp_valid = 1'b0; cmp_irq_req = 1'b0; reg_wr_en = 1'b0;
        reg_wdata = '0;
        #2;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        wait_edges(3);
        rst_n = 1'b1;
        #1;
        // R4: reset state
        chk("R4 reset done", {44'd0, done_count_o}, 64'd0);
        chk("R4 reset irq", {63'd0, irq_o}, 64'd0);
        reg_addr = 2'd2; #1;
        chk("R4 reset wait reg", reg_rdata, 64'd0);
        reg_addr = 2'd3; #1;
        chk("R4 reset enable", reg_rdata, 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][73:71], VEC[i][70:69], {16'd0, VEC[i][68:21]});
            chk({VTAG[i], " table done"}, {44'd0, done_count_o}, {44'd0, VEC[i][20:1]});
            chk({VTAG[i], " table irq"}, {63'd0, irq_o}, {63'd0, VEC[i][0]});
        end

        // R3: readback at addresses 0 and 1
        apply(3'b001, 2'd0, 64'd0);
        apply(3'b001, 2'd0, 64'd0);
        reg_addr = 2'd1; #1;
        chk("R3 ack read", reg_rdata, 64'd2);
        reg_addr = 2'd0; #1;
        chk("R3 done read", reg_rdata, 64'd2);
        apply(3'b010, 2'd1, 64'hFFFF_FFFF_FFF0_0002);
        chk("R2 ack uses low bits", {44'd0, done_count_o}, 64'd0);

        // R11: wait field layout (count limit 100, time limit 1)
        apply(3'b010, 2'd2, 64'hFFFF_0001_FFF0_0064);
        reg_addr = 2'd2; #1;
        chk("R11 wait readback", reg_rdata, 64'h0000_0001_0000_0064);

        // R6: time limit fires at edge k+1024
        apply(3'b001, 2'd0, 64'd0);
        chk("R6 start low", {63'd0, irq_o}, 64'd0);
        wait_edges(1023);
        chk("R6 one edge early", {63'd0, irq_o}, 64'd0);
        wait_edges(1);
        chk("R6 fires", {63'd0, irq_o}, 64'd1);

        // R7: ack of zero restarts the timer
        apply(3'b010, 2'd1, 64'd0);
        chk("R7 restart drops", {63'd0, irq_o}, 64'd0);
        chk("R7 count kept", {44'd0, done_count_o}, 64'd1);
        wait_edges(1023);
        chk("R7 early after restart", {63'd0, irq_o}, 64'd0);
        wait_edges(1);
        chk("R7 fires after restart", {63'd0, irq_o}, 64'd1);

        // R10: direct load also restarts the timer
        apply(3'b010, 2'd0, 64'd4);
        chk("R10 load restarts", {63'd0, irq_o}, 64'd0);
        chk("R10 load value", {44'd0, done_count_o}, 64'd4);

        // R4: idle hold, timer stays zero while nothing is pending
        apply(3'b010, 2'd1, 64'd4);
        wait_edges(2000);
        chk("R4 idle count", {44'd0, done_count_o}, 64'd0);
        chk("R4 idle irq", {63'd0, irq_o}, 64'd0);
        apply(3'b001, 2'd0, 64'd0);
        wait_edges(1023);
        chk("R4 timer held while idle", {63'd0, irq_o}, 64'd0);
        apply(3'b010, 2'd1, 64'd1);

        // R6: time limit zero never fires
        apply(3'b010, 2'd2, 64'd100);
        apply(3'b001, 2'd0, 64'd0);
        wait_edges(1500);
        chk("R6 zero time limit", {63'd0, irq_o}, 64'd0);

        // R4: reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        wait_edges(2);
        rst_n = 1'b1; #1;
        chk("R4 rerun reset count", {44'd0, done_count_o}, 64'd0);
        reg_addr = 2'd2; #1;
        chk("R4 rerun reset wait", reg_rdata, 64'd0);

        ended = 1'b1;
        summary();
        $finish;
    end
endmodule